// File: doc/BRIEF.md
# Group Term-Budget Quantizer

This block accepts a group of four unsigned 8-bit weights together with a term budget. It keeps only the most significant nonzero power-of-two terms of the group, up to that budget. Every set bit counts as one term. The group is scanned as a whole: bit position 7 of all four values first, then position 6, and so on downward. When the budget runs out partway through a bit position, the set bits at that position are granted to the values in ascending index order. Every bit that is not granted is cleared. The block returns the trimmed group together with the number of terms it kept.

The block sits in front of a store of bit-sliced weights, where it raises bit-level sparsity so that each weight column holds fewer ones. A budget of one keeps only the single largest term of the group. A budget that is at least the group's popcount passes the group through untouched. Both ends connect through valid/ready handshakes, and a group moves through a two-stage pipeline: per-position term counts are taken in the first stage and the mask is applied in the second.

Top module: `term_budget_quantizer`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Every bit set in out_vals was set in the corresponding input group (value i occupies bits [8i+7:8i]).
- R3: out_kept equals the smaller of the effective budget and the input group's popcount, and it equals the popcount of out_vals.
- R4: Terms are granted from the highest bit position downward across the whole group. If an input bit at position d is dropped, then no bit at any position below d is kept.
- R5: At the position where the budget runs out, set bits are kept for lower value indices before higher ones.
- R6: A group whose popcount does not exceed the effective budget leaves the block unchanged.
- R7: A budget of 0 clears the whole group and reports 0 kept terms.
- R8: A budget above 32 acts as a budget of 32, so every term is kept.
- R9: A group accepted at a clock edge is presented on the output two edges later while out_ready stays high, and groups leave in the order they arrived.
- R10: While out_valid is high and out_ready is low, out_valid, out_vals and out_kept hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input group is offered |
| in_ready | output | 1 | The block can take an input group |
| in_vals | input | 32 | Four 8-bit weights; value i at bits [8i+7:8i] |
| in_budget | input | 6 | Term budget for this group (0 to 63; values above 32 act as 32) |
| out_valid | output | 1 | A trimmed group is presented |
| out_ready | input | 1 | The consumer takes the presented group |
| out_vals | output | 32 | Trimmed group, laid out the same way as in_vals |
| out_kept | output | 6 | Number of terms kept in out_vals |

## Verification
The checker holds each accepted group and its budget in a four-entry shadow queue and pairs them with the outputs in order of arrival. This assumes that no more than four groups are ever in flight and that nothing is lost between the two handshakes. Both assumptions hold because the pipeline holds at most two groups. The bench changes inputs only between clock edges and drives the output stall from its own random choices. It retries a group until the handshake completes, so it never withdraws one. Budgets are drawn from the whole 6-bit range, values above 32 included, so the clamp is exercised. Weights come from dense, sparse and tie-heavy patterns.

// File: rtl/tbq_pkg.sv
package tbq_pkg;
   localparam int DEF_NUM_VALS = 4;
   localparam int DEF_VAL_W    = 8;

   function automatic int min_int(input int a, input int b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/tbq_plane_count.sv
module tbq_plane_count #(
   parameter int NUM_VALS = 4,
   parameter int VAL_W    = 8,
   parameter int CNT_W    = 3
) (
   input  logic [NUM_VALS*VAL_W-1:0] vals_i,
   output logic [VAL_W*CNT_W-1:0]    cnt_o
);
   for (genvar p = 0; p < VAL_W; p++) begin : g_plane
      logic [CNT_W-1:0] sum;
      always_comb begin
         sum = '0;
         for (int i = 0; i < NUM_VALS; i++)
            sum = sum + CNT_W'(vals_i[i*VAL_W+p]);
      end
      assign cnt_o[p*CNT_W +: CNT_W] = sum;
   end
endmodule

// File: rtl/tbq_mask_gen.sv
module tbq_mask_gen #(
   parameter int NUM_VALS = 4,
   parameter int VAL_W    = 8,
   parameter int CNT_W    = 3,
   parameter int BUD_W    = 6
) (
   input  logic [NUM_VALS*VAL_W-1:0] vals_i,
   input  logic [VAL_W*CNT_W-1:0]    cnt_i,
   input  logic [BUD_W-1:0]          budget_i,
   output logic [NUM_VALS*VAL_W-1:0] vals_o,
   output logic [BUD_W-1:0]          kept_o
);
   // left[p+1] is the budget still free when position p is reached
   logic [VAL_W:0][BUD_W-1:0] left;
   assign left[VAL_W] = budget_i;

   for (genvar p = 0; p < VAL_W; p++) begin : g_pos
      logic [BUD_W-1:0] plane_cnt;
      logic [BUD_W-1:0] plane_take;
      assign plane_cnt  = BUD_W'(cnt_i[p*CNT_W +: CNT_W]);
      assign plane_take = (plane_cnt < left[p+1]) ? plane_cnt : left[p+1];
      assign left[p]    = left[p+1] - plane_take;

      for (genvar i = 0; i < NUM_VALS; i++) begin : g_val
         logic [BUD_W-1:0] ahead;
         always_comb begin
            ahead = '0;
            for (int j = 0; j < i; j++)
               ahead = ahead + BUD_W'(vals_i[j*VAL_W+p]);
         end
         assign vals_o[i*VAL_W+p] = vals_i[i*VAL_W+p] & (ahead < left[p+1]);
      end
   end

   assign kept_o = budget_i - left[0];
endmodule

// File: rtl/term_budget_quantizer.sv
module term_budget_quantizer
   import tbq_pkg::*;
#(
   parameter  int NUM_VALS = DEF_NUM_VALS,
   parameter  int VAL_W    = DEF_VAL_W,
   localparam int TOTAL    = NUM_VALS * VAL_W,
   localparam int BUD_W    = $clog2(TOTAL + 1),
   localparam int CNT_W    = $clog2(NUM_VALS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [TOTAL-1:0] in_vals,
   input  logic [BUD_W-1:0] in_budget,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [TOTAL-1:0] out_vals,
   output logic [BUD_W-1:0] out_kept
);
   if (NUM_VALS < 1) begin : g_bad_num
      $error("NUM_VALS must be at least 1");
   end
   if (VAL_W < 1) begin : g_bad_width
      $error("VAL_W must be at least 1");
   end

   // stage 1: captured group, plane counts, clamped budget
   logic                   s1_v;
   logic [TOTAL-1:0]       s1_vals;
   logic [VAL_W*CNT_W-1:0] s1_cnt;
   logic [BUD_W-1:0]       s1_bud;
   // stage 2: trimmed group
   logic                   s2_v;
   logic [TOTAL-1:0]       s2_vals;
   logic [BUD_W-1:0]       s2_kept;

   logic                   s1_ready, s2_ready;
   logic [VAL_W*CNT_W-1:0] cnt_next;
   logic [BUD_W-1:0]       bud_eff;
   logic [TOTAL-1:0]       trim_vals;
   logic [BUD_W-1:0]       trim_kept;

   assign s2_ready = !s2_v || out_ready;
   assign s1_ready = !s1_v || s2_ready;
   assign in_ready = s1_ready;
   assign bud_eff  = (in_budget > BUD_W'(TOTAL)) ? BUD_W'(TOTAL) : in_budget;

   tbq_plane_count #(
      .NUM_VALS(NUM_VALS), .VAL_W(VAL_W), .CNT_W(CNT_W)
   ) u_count (
      .vals_i(in_vals),
      .cnt_o (cnt_next)
   );

   tbq_mask_gen #(
      .NUM_VALS(NUM_VALS), .VAL_W(VAL_W), .CNT_W(CNT_W), .BUD_W(BUD_W)
   ) u_mask (
      .vals_i  (s1_vals),
      .cnt_i   (s1_cnt),
      .budget_i(s1_bud),
      .vals_o  (trim_vals),
      .kept_o  (trim_kept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_vals <= '0;
         s1_cnt  <= '0;
         s1_bud  <= '0;
      end else if (s1_ready) begin
         s1_v <= in_valid;
         if (in_valid) begin
            s1_vals <= in_vals;
            s1_cnt  <= cnt_next;
            s1_bud  <= bud_eff;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_vals <= '0;
         s2_kept <= '0;
      end else if (s2_ready) begin
         s2_v <= s1_v;
         if (s1_v) begin
            s2_vals <= trim_vals;
            s2_kept <= trim_kept;
         end
      end
   end

   assign out_valid = s2_v;
   assign out_vals  = s2_vals;
   assign out_kept  = s2_kept;
endmodule

// File: rtl/tbq_checker.sv
module tbq_checker
   import tbq_pkg::*;
#(
   parameter  int NUM_VALS = DEF_NUM_VALS,
   parameter  int VAL_W    = DEF_VAL_W,
   localparam int TOTAL    = NUM_VALS * VAL_W,
   localparam int BUD_W    = $clog2(TOTAL + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [TOTAL-1:0] in_vals,
   input logic [BUD_W-1:0] in_budget,
   input logic             out_valid,
   input logic             out_ready,
   input logic [TOTAL-1:0] out_vals,
   input logic [BUD_W-1:0] out_kept
);
   logic [TOTAL-1:0] q_vals [4];
   logic [BUD_W-1:0] q_bud  [4];
   logic [1:0]       wr_ptr, rd_ptr;
   logic [TOTAL-1:0] hv;
   int               hb;

   assign hv = q_vals[rd_ptr];
   assign hb = min_int(int'(q_bud[rd_ptr]), TOTAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         for (int k = 0; k < 4; k++) begin
            q_vals[k] <= '0;
            q_bud[k]  <= '0;
         end
      end else begin
         if (in_valid && in_ready) begin
            q_vals[wr_ptr] <= in_vals;
            q_bud[wr_ptr]  <= in_budget;
            wr_ptr         <= wr_ptr + 2'd1;
         end
         if (out_valid && out_ready)
            rd_ptr <= rd_ptr + 2'd1;
      end
   end

   function automatic int popc(input logic [TOTAL-1:0] v);
      int n = 0;
      for (int k = 0; k < TOTAL; k++) n += int'(v[k]);
      return n;
   endfunction

   function automatic int top_drop(input logic [TOTAL-1:0] h, input logic [TOTAL-1:0] o);
      int d = -1;
      for (int p = 0; p < VAL_W; p++)
         for (int i = 0; i < NUM_VALS; i++)
            if (h[i*VAL_W+p] && !o[i*VAL_W+p]) d = p;
      return d;
   endfunction

   function automatic bit order_ok(input logic [TOTAL-1:0] h, input logic [TOTAL-1:0] o);
      int d = top_drop(h, o);
      for (int p = 0; p < VAL_W; p++)
         for (int i = 0; i < NUM_VALS; i++)
            if (p < d && o[i*VAL_W+p]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit tie_ok(input logic [TOTAL-1:0] h, input logic [TOTAL-1:0] o);
      int d = top_drop(h, o);
      if (d < 0) return 1'b1;
      for (int i = 0; i < NUM_VALS; i++)
         for (int j = 0; j < NUM_VALS; j++)
            if (j > i && h[i*VAL_W+d] && !o[i*VAL_W+d] && o[j*VAL_W+d]) return 1'b0;
      return 1'b1;
   endfunction

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

   a_r2_subset: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_vals & ~hv) == '0));

   a_r3_kept_count: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_kept) == min_int(hb, popc(hv)) && popc(out_vals) == int'(out_kept)));

   a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> order_ok(hv, out_vals));

   a_r5_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> tie_ok(hv, out_vals));

   a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && popc(hv) <= hb) |-> (out_vals == hv));

   a_r7_zero_budget: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && hb == 0) |-> (out_vals == '0 && out_kept == '0));

   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready, 2));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_vals) && $stable(out_kept)));
endmodule

bind term_budget_quantizer tbq_checker #(.NUM_VALS(NUM_VALS), .VAL_W(VAL_W)) u_tbq_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_vals(in_vals), .in_budget(in_budget), .out_valid(out_valid),
   .out_ready(out_ready), .out_vals(out_vals), .out_kept(out_kept)
);

// File: tb/term_budget_quantizer_bench.sv
module term_budget_quantizer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_vals = '0;
   logic [5:0]  in_budget = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_vals;
   logic [5:0]  out_kept;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [31:0] exp_vals [$];
   int          exp_kept [$];
   string       exp_tag  [$];

   bit          was_stalled = 0;
   logic [31:0] held_vals;
   logic [5:0]  held_kept;

   always #5 clk = ~clk;

   term_budget_quantizer u_term_budget_quantizer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_vals(in_vals), .in_budget(in_budget), .out_valid(out_valid),
      .out_ready(out_ready), .out_vals(out_vals), .out_kept(out_kept)
   );

   // Behavioural reference: walk bit positions high to low, values 0..3
   function automatic void ref_trim(input logic [31:0] v, input int bud,
                                    output logic [31:0] o, output int kept);
      int room = (bud > 32) ? 32 : bud;
      o = '0;
      kept = 0;
      for (int p = 7; p >= 0; p--)
         for (int i = 0; i < 4; i++)
            if (v[i*8+p] && room > 0) begin
               o[i*8+p] = 1'b1;
               room--;
               kept++;
            end
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] got,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic finish_test();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // One cycle: drive between edges, then observe the handshakes of the coming edge
   task automatic step(input bit iv, input logic [31:0] v, input logic [5:0] b,
                       input bit ordy, input string tag, output bit acc);
      logic [31:0] rv;
      int          rk;
      @(negedge clk);
      in_valid  = iv;
      in_vals   = v;
      in_budget = b;
      out_ready = ordy;
      #1;
      if (was_stalled) begin // R10
         check(out_valid && out_vals == held_vals && out_kept == held_kept,
               "R10 hold under stall", {out_kept, out_vals[25:0]}, {held_kept, held_vals[25:0]});
      end
      acc = iv && in_ready;
      if (acc) begin
         ref_trim(v, int'(b), rv, rk);
         exp_vals.push_back(rv);
         exp_kept.push_back(rk);
         exp_tag.push_back(tag);
      end
      if (out_valid && out_ready) begin
         if (exp_vals.size() == 0) begin
            check(1'b0, "R9 unexpected output", out_vals, 32'h0);
         end else begin
            logic [31:0] ev = exp_vals.pop_front();
            int          ek = exp_kept.pop_front();
            string       et = exp_tag.pop_front();
            check(out_vals == ev, {et, " vals"}, out_vals, ev);
            check(int'(out_kept) == ek, {et, " kept R3"}, 32'(out_kept), 32'(ek));
         end
      end
      was_stalled = out_valid && !out_ready;
      held_vals   = out_vals;
      held_kept   = out_kept;
   endtask

   task automatic send(input logic [31:0] v, input logic [5:0] b, input bit rnd_ready,
                       input string tag);
      bit acc = 0;
      while (!acc) step(1'b1, v, b, rnd_ready ? ($urandom_range(3) != 0) : 1'b1, tag, acc);
   endtask

   task automatic drain();
      bit acc;
      for (int k = 0; k < 20 && (exp_vals.size() != 0 || out_valid); k++)
         step(1'b0, '0, '0, 1'b1, "drain", acc);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 32'h0, 32'h1);
      finish_test();
   end

   initial begin
      bit acc;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
      check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'h1);

      // R6: sparse group passes unchanged
      send(32'h08040201, 6'd8, 0, "R6 passthrough");
      // R7: zero budget clears
      send(32'hFFFFFFFF, 6'd0, 0, "R7 zero budget");
      // R5: tie at the cut position
      send(32'h80808080, 6'd2, 0, "R5 tie low index");
      send(32'hC0C0C0C0, 6'd5, 0, "R5 partial plane");
      // R4: descending significance across values
      send(32'h8133F00F, 6'd5, 0, "R4 msb first");
      send(32'h01020408, 6'd1, 0, "R4 single term");
      // R8: oversized budget
      send(32'hFFFFFFFF, 6'd40, 0, "R8 clamp");
      send(32'hFFFFFFFF, 6'd32, 0, "R8 full budget");
      send(32'hA5A5A5A5, 6'd63, 0, "R8 max code");
      drain();

      // R9: exact two-edge latency with out_ready held high
      step(1'b1, 32'h00FF0011, 6'd3, 1'b1, "R9 latency", acc);
      step(1'b0, '0, '0, 1'b1, "R9", acc);
      check(out_valid == 1'b0, "R9 not yet after one edge", 32'(out_valid), 32'h0);
      step(1'b0, '0, '0, 1'b1, "R9", acc);
      drain();

      // R10: fill pipeline while stalled, hold, then release
      step(1'b1, 32'h12345678, 6'd4, 1'b0, "R10 first", acc);
      step(1'b1, 32'h9ABCDEF0, 6'd6, 1'b0, "R10 second", acc);
      for (int k = 0; k < 5; k++) step(1'b0, '0, '0, 1'b0, "R10", acc);
      check(in_ready == 1'b0, "R10 full pipeline blocks input", 32'(in_ready), 32'h0);
      drain();

      // R2 R3 R4 R5: random groups and budgets with random backpressure
      for (int n = 0; n < 400; n++) begin
         logic [31:0] v;
         case (n % 3)
            0: v = $urandom();
            1: v = $urandom() & $urandom() & $urandom();
            default: begin
               logic [7:0] b = 8'($urandom());
               v = {b, b, b, b};
            end
         endcase
         send(v, 6'($urandom_range(63)), 1, "R2 R3 random");
      end
      drain();
      check(exp_vals.size() == 0, "R9 all groups returned", 32'(exp_vals.size()), 32'h0);
      finish_test();
   end
endmodule